// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache with Block Refill

This block sits between a processor port and a slower word-wide memory port. Each line keeps a valid flag, a tag and a block of several 32-bit words, and every block in memory has exactly one line it can occupy. The index of that line is the block address modulo the number of lines. The processor gives a byte address and keeps its request up until `cpu_ready` rises. A hit is served in the same cycle. A miss holds `cpu_ready` low while the whole block is read from memory one word per beat, lowest word first. The access is then retried and completes as a hit.

Stores go to the cache and also to memory. The memory copy passes through a one-entry store buffer, so a store whose buffer slot is free finishes without waiting for memory. A store that misses first loads its block and then merges its word into it. A refill never begins while a buffered store is still waiting, which keeps memory ahead of any block that is read back.

Top module: `dm_cache`

## Requirements
- R1: The word address is `cpu_addr[31:2]`. With the default 4-word lines and 16 lines, `cpu_addr[3:2]` picks the word, `cpu_addr[7:4]` picks the line and `cpu_addr[31:8]` is the tag. Byte address 1200 is word 300 and block 75, and it maps to line 11.
- R2: After reset every line is invalid, so the first access to any address misses and reads memory.
- R3: A read whose line is valid and whose tag matches raises `cpu_ready` in the cycle it is presented and returns the cached word on `cpu_rdata`. It makes no memory read.
- R4: On a read miss the block is fetched as `LINE_WORDS` memory reads (`mem_we`=0) at ascending word addresses, starting at the block-aligned word address. `cpu_ready` stays low throughout. When memory is always ready and the store buffer is empty, a miss first presented in cycle k completes in cycle k+5.
- R5: A store miss loads the whole block first and then merges the stored word. The line then returns the new word at the stored address and the memory contents at the other offsets. It completes in cycle k+5 under the conditions of R4.
- R6: A store hit updates the cached word. It also produces exactly one memory write (`mem_we`=1) of that word at its word address.
- R7: When the store buffer is empty, a store hit completes in the cycle it is presented. When the buffer is full, a store is held (`cpu_ready`=0) until memory accepts the buffered write, and it completes in the cycle after that acceptance.
- R8: A miss does not start its refill while a store is buffered. The pending memory write is accepted before the first refill read, so a block read back after eviction contains the stored word.
- R9: A block that maps to an occupied line evicts the block held there, so the evicted block misses on its next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address; the two low bits are ignored |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid when `cpu_ready` is high on a load |
| cpu_ready | output | 1 | Access completes at this clock edge |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | 30 | Memory word address |
| mem_wdata | output | 32 | Write beat data |
| mem_rdata | input | 32 | Read beat data, valid alongside `mem_ready` |
| mem_ready | input | 1 | Memory accepts the current beat at this edge |

## Verification
Hits complete in the cycle the request is presented. A miss with an idle, always-ready memory completes five cycles after it is first presented: four refill beats follow, then the retried lookup. A store that finds the buffer full completes one cycle after the memory accepts the buffered write. The bench drives requests just after the falling edge and samples `cpu_ready` and `cpu_rdata` 1 ns later. It counts the falling edges that pass before `cpu_ready` rises and compares that count with these figures. It also logs every accepted memory beat at the rising edge, so the order and addresses of refill reads and write-through writes are checked against the expected sequence.

// File: rtl/cache_pkg.sv
// Shared types for the direct-mapped cache.
// Assumes: nothing beyond IEEE 1800-2017.
package cache_pkg;

    // Refill controller state: idle lookup or block fetch in progress.
    typedef enum logic {
        FILL_IDLE = 1'b0,
        FILL_RUN  = 1'b1
    } fill_state_e;

endpackage

// File: rtl/cache_store.sv
// Line storage: valid flags, tags and data words for every line.
// Reads are combinational; writes, tag updates and valid changes are
// synchronous. Assumes set_en and clr_en are never active together.
module cache_store #(
    parameter int DATA_W = 32,
    parameter int OFF_W  = 2,
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [OFF_W-1:0]  rd_off,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_word,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              set_en,
    input  logic [IDX_W-1:0]  set_idx,
    input  logic [TAG_W-1:0]  set_tag,
    input  logic              clr_en,
    input  logic [IDX_W-1:0]  clr_idx
);
    localparam int LINES = 1 << IDX_W;
    localparam int WORDS = 1 << OFF_W;

    logic [DATA_W-1:0] data_q [LINES][WORDS];
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [LINES-1:0]  valid_q;

    // Per-line valid flag: cleared at reset and at refill start, set when the refill ends.
    for (genvar i = 0; i < LINES; i++) begin : g_valid
        always_ff @(posedge clk) begin
            if (!rst_n)
                valid_q[i] <= 1'b0;
            else if (set_en && set_idx == IDX_W'(i))
                valid_q[i] <= 1'b1;
            else if (clr_en && clr_idx == IDX_W'(i))
                valid_q[i] <= 1'b0;
        end
    end

    // Tag capture when a refill completes.
    always_ff @(posedge clk) begin
        if (set_en)
            tag_q[set_idx] <= set_tag;
    end

    // Word write from a refill beat or a store hit.
    always_ff @(posedge clk) begin
        if (wr_en)
            data_q[wr_idx][wr_off] <= wr_data;
    end

    // Combinational lookup of the addressed line.
    always_comb begin
        rd_valid = valid_q[rd_idx];
        rd_tag   = tag_q[rd_idx];
        rd_word  = data_q[rd_idx][rd_off];
    end

    // R4: a line is never marked valid and invalid in one cycle.
    p_set_clr_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_en && clr_en));

    // R2, R4: a line whose refill has just completed reads back as valid.
    p_valid_after_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> valid_q[$past(set_idx)]);

endmodule

// File: rtl/refill_ctrl.sv
// Block refill sequencer. On start it latches the block address and
// issues one memory read per word, lowest word first, moving on only
// when memory accepts a beat. Assumes start is raised only while idle.
module refill_ctrl #(
    parameter int BLK_W = 28,
    parameter int OFF_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [BLK_W-1:0] blk_in,
    input  logic             mem_ready,
    output logic             busy,
    output logic [BLK_W-1:0] blk_q,
    output logic [OFF_W-1:0] beat,
    output logic             beat_take,
    output logic             done
);
    import cache_pkg::*;

    localparam logic [OFF_W-1:0] LAST_BEAT = '1;

    fill_state_e state_q;

    // State, block address and beat counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FILL_IDLE;
            blk_q   <= '0;
            beat    <= '0;
        end else if (state_q == FILL_IDLE) begin
            if (start) begin
                state_q <= FILL_RUN;
                blk_q   <= blk_in;
                beat    <= '0;
            end
        end else if (beat_take) begin
            beat <= beat + 1'b1;
            if (beat == LAST_BEAT)
                state_q <= FILL_IDLE;
        end
    end

    // Beat acceptance and completion strobes.
    always_comb begin
        busy      = (state_q == FILL_RUN);
        beat_take = busy && mem_ready;
        done      = beat_take && (beat == LAST_BEAT);
    end

    // R4: the refill ends right after its last beat is accepted.
    p_fill_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R4: without an accepted beat the beat position does not move.
    p_beat_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !mem_ready |=> busy && $stable(beat) && $stable(blk_q));

endmodule

// File: rtl/store_buffer.sv
// Single-entry holding register for write-through stores. It keeps
// address and data stable until memory accepts them. Assumes push is
// raised only while the entry is empty.
module store_buffer #(
    parameter int AW = 30,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic          full,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] data_q
);
    // Occupancy flag.
    always_ff @(posedge clk) begin
        if (!rst_n)
            full <= 1'b0;
        else if (push)
            full <= 1'b1;
        else if (pop)
            full <= 1'b0;
    end

    // Captured store payload.
    always_ff @(posedge clk) begin
        if (push) begin
            addr_q <= push_addr;
            data_q <= push_data;
        end
    end

    // R7: a store is never written over a waiting one.
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R7: a waiting store keeps its address and data until accepted.
    p_hold_until_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        full && !pop |=> full && $stable(addr_q) && $stable(data_q));

endmodule

// File: rtl/dm_cache.sv
// Direct-mapped, write-through, write-allocate cache with multiword lines.
// A processor request is held until cpu_ready. Hits finish in one cycle.
// A miss waits for the store buffer to drain, refills the whole line
// and then retries as a hit. Assumes a memory that returns mem_rdata
// in the same cycle as mem_ready on a read beat.
module dm_cache #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter int NUM_LINES  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-3:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready
);
    localparam int WADDR_W = ADDR_W - 2;
    localparam int OFF_W   = $clog2(LINE_WORDS);
    localparam int IDX_W   = $clog2(NUM_LINES);
    localparam int BLK_W   = WADDR_W - OFF_W;
    localparam int TAG_W   = BLK_W - IDX_W;

    logic [WADDR_W-1:0] word_addr;
    logic [OFF_W-1:0]   cpu_off;
    logic [IDX_W-1:0]   cpu_idx;
    logic [TAG_W-1:0]   cpu_tag;
    logic               unused_byte_lo;

    logic               rd_valid;
    logic [TAG_W-1:0]   rd_tag;
    logic [DATA_W-1:0]  rd_word;

    logic               busy, beat_take, done, start;
    logic [BLK_W-1:0]   blk_q;
    logic [OFF_W-1:0]   beat;

    logic               wb_full, wb_push, wb_pop;
    logic [WADDR_W-1:0] wb_addr;
    logic [DATA_W-1:0]  wb_data;

    logic               hit, miss, store_go;
    logic               wr_en;
    logic [IDX_W-1:0]   wr_idx;
    logic [OFF_W-1:0]   wr_off;
    logic [DATA_W-1:0]  wr_data;

    // Address split into word offset, line index and tag.
    always_comb begin
        word_addr      = cpu_addr[ADDR_W-1:2];
        cpu_off        = word_addr[OFF_W-1:0];
        cpu_idx        = word_addr[OFF_W +: IDX_W];
        cpu_tag        = word_addr[WADDR_W-1 -: TAG_W];
        unused_byte_lo = ^cpu_addr[1:0];
    end

    cache_store #(
        .DATA_W (DATA_W),
        .OFF_W  (OFF_W),
        .IDX_W  (IDX_W),
        .TAG_W  (TAG_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (cpu_idx),
        .rd_off   (cpu_off),
        .rd_valid (rd_valid),
        .rd_tag   (rd_tag),
        .rd_word  (rd_word),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_off   (wr_off),
        .wr_data  (wr_data),
        .set_en   (done),
        .set_idx  (blk_q[IDX_W-1:0]),
        .set_tag  (blk_q[BLK_W-1:IDX_W]),
        .clr_en   (start),
        .clr_idx  (cpu_idx)
    );

    refill_ctrl #(
        .BLK_W (BLK_W),
        .OFF_W (OFF_W)
    ) u_refill (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .blk_in    (word_addr[WADDR_W-1:OFF_W]),
        .mem_ready (mem_ready),
        .busy      (busy),
        .blk_q     (blk_q),
        .beat      (beat),
        .beat_take (beat_take),
        .done      (done)
    );

    store_buffer #(
        .AW (WADDR_W),
        .DW (DATA_W)
    ) u_wbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wb_push),
        .push_addr (word_addr),
        .push_data (cpu_wdata),
        .pop       (wb_pop),
        .full      (wb_full),
        .addr_q    (wb_addr),
        .data_q    (wb_data)
    );

    // Hit detection, miss start and processor handshake.
    always_comb begin
        hit       = cpu_req && !busy && rd_valid && (rd_tag == cpu_tag);
        miss      = cpu_req && !busy && !hit;
        start     = miss && !wb_full;
        store_go  = hit && cpu_we && !wb_full;
        cpu_ready = hit && (!cpu_we || !wb_full);
        cpu_rdata = rd_word;
        wb_push   = store_go;
    end

    // Line write source: refill beat or store hit.
    always_comb begin
        wr_en   = beat_take || store_go;
        wr_idx  = busy ? blk_q[IDX_W-1:0] : cpu_idx;
        wr_off  = busy ? beat : cpu_off;
        wr_data = busy ? mem_rdata : cpu_wdata;
    end

    // Memory port: refill reads while busy, otherwise buffered store drain.
    always_comb begin
        if (busy) begin
            mem_req   = 1'b1;
            mem_we    = 1'b0;
            mem_addr  = {blk_q, beat};
            mem_wdata = wb_data;
        end else begin
            mem_req   = wb_full;
            mem_we    = 1'b1;
            mem_addr  = wb_addr;
            mem_wdata = wb_data;
        end
        wb_pop = !busy && wb_full && mem_ready;
    end

    // R4: during a refill the port only reads.
    p_fill_is_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> mem_req && !mem_we);

    // R4: the processor is held for the whole refill.
    p_stall_in_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !cpu_ready);

    // R8: a refill never runs while a store waits in the buffer.
    p_fill_after_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !wb_full);

    // R6: a completed store leaves a memory write pending next cycle.
    p_store_queued_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready && cpu_we |=> mem_req && mem_we);

endmodule

// File: tb/tb_dm_cache.sv
module tb_dm_cache;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_req, cpu_we;
    logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
    logic        cpu_ready;
    logic        mem_req, mem_we;
    logic [29:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic        mem_ready;

    int checks = 0;
    int errors = 0;

    logic [31:0] mem_arr [4096];
    logic [31:0] shadow  [4096];
    logic        log_we   [1024];
    logic [29:0] log_addr [1024];
    logic [31:0] log_data [1024];
    int          log_n = 0;

    always #4 clk = ~clk;

    dm_cache dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (cpu_rdata),
        .cpu_ready (cpu_ready),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ready (mem_ready)
    );

    // Memory model: zero-latency data, accept when mem_ready.
    assign mem_rdata = mem_arr[mem_addr[11:0]];

    always @(posedge clk) begin
        if (rst_n && mem_req && mem_ready) begin
            if (mem_we) mem_arr[mem_addr[11:0]] = mem_wdata;
            if (log_n < 1024) begin
                log_we[log_n]   = mem_we;
                log_addr[log_n] = mem_addr;
                log_data[log_n] = mem_wdata;
                log_n = log_n + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic access(input bit we, input logic [31:0] a, input logic [31:0] wd,
                          output logic [31:0] rd, output int cyc);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        cyc = 0;
        #1;
        while (!cpu_ready) begin
            cyc++;
            @(negedge clk);
            #1;
        end
        rd = cpu_rdata;
        @(posedge clk);
        #1;
        cpu_req = 1'b0; cpu_we = 1'b0;
        if (we) shadow[a[13:2]] = wd;
    endtask

    // Checks that entries from 'first' are an ascending block read starting at word w0.
    task automatic chk_fill(input int first, input int w0, input string req);
        for (int i = 0; i < 4; i++) begin
            chk(log_we[first+i] == 1'b0, req, 32'(log_we[first+i]), 32'd0);
            chk(log_addr[first+i] == 30'(w0 + i), req, 32'(log_addr[first+i]), 32'(w0 + i));
        end
    endtask

    task automatic t_reset();
        @(negedge clk); #1;
        chk(cpu_ready == 1'b0, "R2 reset ready", 32'(cpu_ready), 32'd0);
        chk(mem_req == 1'b0, "R2 reset mem_req", 32'(mem_req), 32'd0);
    endtask

    task automatic t_read_miss();
        logic [31:0] rd; int cyc; int n0;
        n0 = log_n;
        access(1'b0, 32'd1200, 32'd0, rd, cyc);
        chk(cyc == 5, "R4 miss latency", 32'(cyc), 32'd5);
        chk(rd == shadow[300], "R2 R4 miss data", rd, shadow[300]);
        chk(log_n - n0 == 4, "R4 beat count", 32'(log_n - n0), 32'd4);
        chk_fill(n0, 300, "R1 R4 block words");
    endtask

    task automatic t_read_hit();
        logic [31:0] rd; int cyc; int n0;
        n0 = log_n;
        for (int i = 0; i < 4; i++) begin
            access(1'b0, 32'd1200 + 32'(4*i), 32'd0, rd, cyc);
            chk(cyc == 0, "R3 hit latency", 32'(cyc), 32'd0);
            chk(rd == shadow[300+i], "R3 hit data", rd, shadow[300+i]);
        end
        chk(log_n == n0, "R3 no memory read", 32'(log_n - n0), 32'd0);
    endtask

    task automatic t_conflict();
        logic [31:0] rd; int cyc; int n0;
        n0 = log_n;
        access(1'b0, 32'd1456, 32'd0, rd, cyc);
        chk(cyc == 5, "R9 conflict misses", 32'(cyc), 32'd5);
        chk(rd == shadow[364], "R9 conflict data", rd, shadow[364]);
        chk_fill(n0, 364, "R1 line 11 alias");
        access(1'b0, 32'd1204, 32'd0, rd, cyc);
        chk(cyc == 5, "R9 evicted block misses", 32'(cyc), 32'd5);
        chk(rd == shadow[301], "R9 refetch data", rd, shadow[301]);
    endtask

    task automatic t_write_hit();
        logic [31:0] rd; int cyc; int n0;
        n0 = log_n;
        access(1'b1, 32'd1208, 32'hCAFE_0001, rd, cyc);
        chk(cyc == 0, "R7 store empty buffer", 32'(cyc), 32'd0);
        repeat (2) @(negedge clk);
        chk(log_n - n0 == 1, "R6 one memory write", 32'(log_n - n0), 32'd1);
        chk(log_we[n0] == 1'b1 && log_addr[n0] == 30'd302, "R6 write addr", 32'(log_addr[n0]), 32'd302);
        chk(log_data[n0] == 32'hCAFE_0001, "R6 write data", log_data[n0], 32'hCAFE_0001);
        access(1'b0, 32'd1208, 32'd0, rd, cyc);
        chk(cyc == 0 && rd == 32'hCAFE_0001, "R6 cache updated", rd, 32'hCAFE_0001);
    endtask

    task automatic t_write_miss();
        logic [31:0] rd; int cyc; int n0;
        n0 = log_n;
        access(1'b1, 32'd2000, 32'hBEEF_0500, rd, cyc);
        chk(cyc == 5, "R5 store miss latency", 32'(cyc), 32'd5);
        repeat (2) @(negedge clk);
        chk_fill(n0, 500, "R5 fill before merge");
        chk(log_we[n0+4] == 1'b1 && log_addr[n0+4] == 30'd500, "R5 write after fill",
            32'(log_addr[n0+4]), 32'd500);
        for (int i = 0; i < 4; i++) begin
            access(1'b0, 32'd2000 + 32'(4*i), 32'd0, rd, cyc);
            chk(cyc == 0, "R5 line now valid", 32'(cyc), 32'd0);
            chk(rd == shadow[500+i], "R5 merged line", rd, shadow[500+i]);
        end
    endtask

    task automatic t_buffer_full();
        logic [31:0] rd; int cyc; int n0;
        mem_ready = 1'b0;
        access(1'b1, 32'd1200, 32'h1111_2222, rd, cyc);
        chk(cyc == 0, "R7 first store no wait", 32'(cyc), 32'd0);
        n0 = log_n;
        fork
            access(1'b1, 32'd1204, 32'h3333_4444, rd, cyc);
            begin
                repeat (3) @(negedge clk);
                mem_ready = 1'b1;
            end
        join
        chk(cyc == 3, "R7 store held until drain", 32'(cyc), 32'd3);
        repeat (2) @(negedge clk);
        chk(log_addr[n0] == 30'd300 && log_data[n0] == 32'h1111_2222, "R7 first drained first",
            log_data[n0], 32'h1111_2222);
        chk(log_addr[n0+1] == 30'd301 && log_data[n0+1] == 32'h3333_4444, "R7 second drained",
            log_data[n0+1], 32'h3333_4444);
    endtask

    task automatic t_order();
        logic [31:0] rd; int cyc; int n0;
        mem_ready = 1'b0;
        access(1'b1, 32'd1212, 32'h5A5A_0303, rd, cyc);
        n0 = log_n;
        fork
            access(1'b0, 32'd1456, 32'd0, rd, cyc);
            begin
                repeat (3) @(negedge clk);
                mem_ready = 1'b1;
            end
        join
        chk(log_we[n0] == 1'b1 && log_addr[n0] == 30'd303, "R8 store before refill",
            32'(log_addr[n0]), 32'd303);
        chk_fill(n0 + 1, 364, "R8 refill after store");
        chk(rd == shadow[364], "R8 conflict data", rd, shadow[364]);
        access(1'b0, 32'd1212, 32'd0, rd, cyc);
        chk(cyc == 5, "R8 R9 refetch misses", 32'(cyc), 32'd5);
        chk(rd == 32'h5A5A_0303, "R8 refetched stored word", rd, 32'h5A5A_0303);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) begin
            mem_arr[i] = 32'h1357_0000 + 32'(i) * 32'h0001_0203;
            shadow[i]  = mem_arr[i];
        end
        rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0;
        cpu_addr = '0; cpu_wdata = '0; mem_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_read_miss();
        t_read_hit();
        t_conflict();
        t_write_hit();
        t_write_miss();
        t_buffer_full();
        t_order();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule